// File: doc/BRIEF.md
# Shared Pattern Memory with Windowed Host Access

This block holds a 512-byte repeating test pattern. Two parties use it: a host on a small register bus, and a pattern-generator engine that pulls bytes one at a time. A single ownership bit decides which party has the memory. While the host owns it, one register address works as a data window. Each write through the window stores a byte at an internal 9-bit pointer, and each read through it returns the byte at the pointer. The pointer advances after every accepted access. Setting the ownership bit from 0 to 1 returns the pointer to address 0.

The host also programs the last valid pattern address as a 9-bit value. Its low byte sits in its own register and its top bit sits in the control register. Once ownership passes back to the engine, the engine reads from address 0 upward, one byte per request. After it delivers the byte at the last address it wraps to 0, so the pattern repeats with a period of last address plus one.

Register layout (host address, 4 bits): 3h holds the low 8 bits of the last address. 4h is the control register: bit 3 is ownership (1 = host), bit 4 is read mode, bit 0 is bit 8 of the last address, and all other bits read as 0. Fh is the data window. Every host access is a single-cycle strobe.

Top module: `patmem_ctrl`

## Requirements
- R1: After reset, ownership, read mode and the last address are 0, `hostRdData`, `engData` and `engValid` are 0, and reads of registers 3h and 4h return 00h.
- R2: A host write to 4h sets ownership from bit 3, read mode from bit 4 and last-address bit 8 from bit 0. A write to 3h sets the low byte. A host read returns these values in the same bit positions, with every other bit of 4h reading 0.
- R3: A write to 4h that takes ownership from 0 to 1 sets the pointer to 0. A write that leaves ownership at 1 does not move the pointer.
- R4: With ownership 1 and read mode 0, a host write to Fh stores the byte at the pointer, and the pointer then advances by one.
- R5: With ownership 1 and read mode 1, a host read of Fh returns the byte at the pointer on `hostRdData` one cycle after the read strobe, and the pointer then advances by one.
- R6: The pointer wraps from 511 to 0. A 513th window write overwrites address 0.
- R7: The following window accesses neither store a byte nor move the pointer: writes while ownership is 0 or read mode is 1, and reads while ownership is 0 or read mode is 0. Such reads return 00h.
- R8: When ownership goes from 1 to 0, the engine address returns to 0. Each engine request while ownership is 0 returns the byte at the engine address on `engData`, with `engValid` high, one cycle later. After the byte at the last address, the engine address wraps to 0.
- R9: Engine requests while the host owns the memory are ignored: `engValid` stays 0 and `engData` holds its value.
- R10: A last address above 255 takes bit 8 from control bit 0, so the engine period reaches up to 512 bytes.
- R11: A host read of any address other than 3h, 4h or Fh returns 00h. `hostRdData` holds its value between read strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostAddr | input | 4 | Host register address |
| hostWrData | input | 8 | Host write data |
| hostWrEn | input | 1 | Single-cycle host write strobe |
| hostRdEn | input | 1 | Single-cycle host read strobe |
| hostRdData | output | 8 | Registered host read data, valid the cycle after the read strobe |
| engReq | input | 1 | Engine byte request, one per cycle |
| engValid | output | 1 | Engine byte valid, one cycle after an accepted request |
| engData | output | 8 | Engine pattern byte |

## Verification
The bench loads patterns through the window and reads them back. It places an ignored window write in the middle of a readback; a design that advanced the pointer on ignored accesses would return every later byte from the wrong address. Engine sequences are checked for exact period with a short last address and with one above 255. A design that ignored control bit 0 would repeat after 44 bytes instead of 300, and one that missed the handover reset would start mid-pattern. A 513-byte load checks that the pointer wraps onto address 0 rather than stalling or spilling.

// File: rtl/patmem_pkg.sv
package patmem_pkg;

  localparam int PM_ADDR_W = 9;
  localparam int PM_DATA_W = 8;
  localparam int PM_REG_AW = 4;

  // host read data source chosen by control, latched by datapath
  typedef enum logic [1:0] {
    RD_HOLD = 2'd0,
    RD_ZERO = 2'd1,
    RD_RAM  = 2'd2,
    RD_REG  = 2'd3
  } rdSel_t;

  typedef struct packed {
    logic   ramWr;    // store host byte at pointer
    logic   engStep;  // engine request accepted
    logic   engClr;   // ownership handed back to engine
    logic   hostOwn;  // current ownership
    rdSel_t rdSel;    // host read data source
  } strobe_t;

endpackage

// File: rtl/patmem_ctl.sv
module patmem_ctl
  import patmem_pkg::*;
#(
  parameter int ADDR_W    = PM_ADDR_W,
  parameter int DATA_W    = PM_DATA_W,
  parameter int REG_AW    = PM_REG_AW,
  parameter logic [REG_AW-1:0] END_ADDR  = 4'h3,
  parameter logic [REG_AW-1:0] CTRL_ADDR = 4'h4,
  parameter logic [REG_AW-1:0] WIN_ADDR  = 4'hF,
  parameter int OWN_BIT   = 3,
  parameter int RMODE_BIT = 4,
  parameter int ENDHI_BIT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic              engReq,
  output strobe_t           strb,
  output logic [ADDR_W-1:0] hostPtr,
  output logic [ADDR_W-1:0] patEnd,
  output logic [DATA_W-1:0] regRdVal
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic              own;
  logic              rdMode;
  logic [HI_W-1:0]   endHi;
  logic [DATA_W-1:0] endLo;

  logic hitCtrl, hitEnd, hitWin;
  logic ctrlWrite, nextOwn;
  logic winRead, winWrite;

  assign hitCtrl   = (hostAddr == CTRL_ADDR);
  assign hitEnd    = (hostAddr == END_ADDR);
  assign hitWin    = (hostAddr == WIN_ADDR);
  assign ctrlWrite = hostWrEn && hitCtrl;
  assign nextOwn   = hostWrData[OWN_BIT];
  assign winWrite  = hostWrEn && hitWin && own && !rdMode;
  assign winRead   = hostRdEn && hitWin && own && rdMode;

  // control register slice
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      own    <= 1'b0;
      rdMode <= 1'b0;
      endHi  <= '0;
      endLo  <= '0;
    end else begin
      if (ctrlWrite) begin
        own    <= nextOwn;
        rdMode <= hostWrData[RMODE_BIT];
        endHi  <= hostWrData[ENDHI_BIT +: HI_W];
      end
      if (hostWrEn && hitEnd) begin
        endLo <= hostWrData;
      end
    end
  end

  assign patEnd = {endHi, endLo};

  // window pointer: cleared when host takes ownership, advances after access
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostPtr <= '0;
    end else if (ctrlWrite && nextOwn && !own) begin
      hostPtr <= '0;
    end else if (winWrite || winRead) begin
      hostPtr <= hostPtr + 1'b1;
    end
  end

  // register read image
  always_comb begin
    regRdVal = '0;
    if (hitCtrl) begin
      regRdVal[OWN_BIT]             = own;
      regRdVal[RMODE_BIT]           = rdMode;
      regRdVal[ENDHI_BIT +: HI_W]   = endHi;
    end else if (hitEnd) begin
      regRdVal = endLo;
    end
  end

  // strobes to the datapath
  always_comb begin
    strb.ramWr   = winWrite;
    strb.engStep = engReq && !own;
    strb.engClr  = ctrlWrite && !nextOwn && own;
    strb.hostOwn = own;
    if (!hostRdEn) begin
      strb.rdSel = RD_HOLD;
    end else if (winRead) begin
      strb.rdSel = RD_RAM;
    end else if (hitCtrl || hitEnd) begin
      strb.rdSel = RD_REG;
    end else begin
      strb.rdSel = RD_ZERO;
    end
  end

  // R3
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(own) |-> hostPtr == '0);

  // R7
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !own |=> (own || $stable(hostPtr)));

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (winWrite || winRead) |=> hostPtr == ADDR_W'($past(hostPtr) + 1'b1));

  // R7
  wr_owner_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.ramWr |-> (own && !rdMode));

endmodule

// File: rtl/patmem_dp.sv
module patmem_dp
  import patmem_pkg::*;
#(
  parameter int ADDR_W = PM_ADDR_W,
  parameter int DATA_W = PM_DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] hostPtr,
  input  logic [ADDR_W-1:0] patEnd,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic [DATA_W-1:0] regRdVal,
  output logic [DATA_W-1:0] hostRdData,
  output logic [DATA_W-1:0] engData,
  output logic              engValid
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] engAddr;
  logic [ADDR_W-1:0] rdAddr;
  logic [DATA_W-1:0] rdByte;

  // one read port, address chosen by the owner
  assign rdAddr = strb.hostOwn ? hostPtr : engAddr;
  assign rdByte = mem[rdAddr];

  always_ff @(posedge clk) begin
    if (strb.ramWr) begin
      mem[hostPtr] <= hostWrData;
    end
  end

  // engine sequential address with wrap at the last pattern address
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      engAddr <= '0;
    end else if (strb.engClr) begin
      engAddr <= '0;
    end else if (strb.engStep) begin
      engAddr <= (engAddr == patEnd) ? '0 : engAddr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      engValid <= 1'b0;
      engData  <= '0;
    end else begin
      engValid <= strb.engStep;
      if (strb.engStep) begin
        engData <= rdByte;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostRdData <= '0;
    end else begin
      unique case (strb.rdSel)
        RD_HOLD: hostRdData <= hostRdData;
        RD_ZERO: hostRdData <= '0;
        RD_RAM:  hostRdData <= rdByte;
        RD_REG:  hostRdData <= regRdVal;
        default: hostRdData <= '0;
      endcase
    end
  end

  // R8
  eng_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.engStep && !strb.engClr && engAddr == patEnd) |=> engAddr == '0);

  // R9
  eng_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.hostOwn |=> !engValid);

  // R8
  eng_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.engClr |=> engAddr == '0);

endmodule

// File: rtl/patmem_ctrl.sv
module patmem_ctrl
  import patmem_pkg::*;
#(
  parameter int ADDR_W = PM_ADDR_W,
  parameter int DATA_W = PM_DATA_W,
  parameter int REG_AW = PM_REG_AW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  output logic [DATA_W-1:0] hostRdData,
  input  logic              engReq,
  output logic              engValid,
  output logic [DATA_W-1:0] engData
);

  strobe_t           strb;
  logic [ADDR_W-1:0] hostPtr;
  logic [ADDR_W-1:0] patEnd;
  logic [DATA_W-1:0] regRdVal;

  patmem_ctl #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .REG_AW (REG_AW)
  ) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .hostAddr   (hostAddr),
    .hostWrData (hostWrData),
    .hostWrEn   (hostWrEn),
    .hostRdEn   (hostRdEn),
    .engReq     (engReq),
    .strb       (strb),
    .hostPtr    (hostPtr),
    .patEnd     (patEnd),
    .regRdVal   (regRdVal)
  );

  patmem_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .hostPtr    (hostPtr),
    .patEnd     (patEnd),
    .hostWrData (hostWrData),
    .regRdVal   (regRdVal),
    .hostRdData (hostRdData),
    .engData    (engData),
    .engValid   (engValid)
  );

endmodule

// File: tb/patmem_ctrl_bench.sv
`timescale 1ns/1ps
module patmem_ctrl_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] hostAddr = '0;
  logic [7:0] hostWrData = '0;
  logic       hostWrEn = 1'b0;
  logic       hostRdEn = 1'b0;
  logic       engReq = 1'b0;
  logic [7:0] hostRdData;
  logic       engValid;
  logic [7:0] engData;

  patmem_ctrl u_patmem_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .hostAddr   (hostAddr),
    .hostWrData (hostWrData),
    .hostWrEn   (hostWrEn),
    .hostRdEn   (hostRdEn),
    .hostRdData (hostRdData),
    .engReq     (engReq),
    .engValid   (engValid),
    .engData    (engData)
  );

  always #4 clk = ~clk;

  int    errors = 0;
  int    checks = 0;
  string tag = "R1";
  bit    done = 1'b0;

  task automatic check(string t, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  // behavioural reference model
  int mMem [512];
  int mOwn = 0, mRm = 0, mEnd = 0, mPtr = 0, mEngA = 0;
  int mHostRd = 0, mEngD = 0, mEngV = 0;
  int nOwn;

  always @(posedge clk) begin
    if (!rstN) begin
      mOwn = 0; mRm = 0; mEnd = 0; mPtr = 0; mEngA = 0;
      mHostRd = 0; mEngD = 0; mEngV = 0;
    end else begin
      if (engReq && mOwn == 0) begin
        mEngD = mMem[mEngA];
        mEngV = 1;
        mEngA = (mEngA == mEnd) ? 0 : (mEngA + 1) % 512;
      end else begin
        mEngV = 0;
      end
      if (hostRdEn) begin
        if (hostAddr == 4'h4)
          mHostRd = mOwn * 8 + mRm * 16 + mEnd / 256;
        else if (hostAddr == 4'h3)
          mHostRd = mEnd % 256;
        else if (hostAddr == 4'hF && mOwn == 1 && mRm == 1) begin
          mHostRd = mMem[mPtr];
          mPtr = (mPtr + 1) % 512;
        end else
          mHostRd = 0;
      end
      if (hostWrEn) begin
        if (hostAddr == 4'h4) begin
          nOwn = int'(hostWrData[3]);
          if (nOwn == 1 && mOwn == 0) mPtr = 0;
          if (nOwn == 0 && mOwn == 1) mEngA = 0;
          mOwn = nOwn;
          mRm  = int'(hostWrData[4]);
          mEnd = int'(hostWrData[0]) * 256 + mEnd % 256;
        end else if (hostAddr == 4'h3) begin
          mEnd = (mEnd / 256) * 256 + int'(hostWrData);
        end else if (hostAddr == 4'hF && mOwn == 1 && mRm == 0) begin
          mMem[mPtr] = int'(hostWrData);
          mPtr = (mPtr + 1) % 512;
        end
      end
    end
  end

  // compare against the model every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      check(tag, "hostRdData", int'(hostRdData), mHostRd);
      check(tag, "engValid", int'(engValid), mEngV);
      check(tag, "engData", int'(engData), mEngD);
    end
  end

  // all tasks start and end at a falling edge
  task automatic hostWrite(input logic [3:0] a, input logic [7:0] d);
    hostAddr = a; hostWrData = d; hostWrEn = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [3:0] a, output int d);
    hostAddr = a; hostRdEn = 1'b1;
    @(negedge clk);
    hostRdEn = 1'b0;
    d = int'(hostRdData);
  endtask

  int engQ [$];
  task automatic engPull(input int n);
    engQ.delete();
    engReq = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      engQ.push_back(int'(engData));
    end
    engReq = 1'b0;
  endtask

  int pat [512];
  int rd;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    tag = "R1";
    hostRead(4'h4, rd); check("R1", "ctrl after reset", rd, 0);
    hostRead(4'h3, rd); check("R1", "end low after reset", rd, 0);

    // R2 register fields
    tag = "R2";
    hostWrite(4'h3, 8'h05);
    hostWrite(4'h4, 8'h08);
    hostRead(4'h4, rd); check("R2", "ctrl readback", rd, 8'h08);
    hostRead(4'h3, rd); check("R2", "end low readback", rd, 8'h05);

    // R11 unmapped address
    tag = "R11";
    hostRead(4'h7, rd); check("R11", "unmapped read", rd, 0);

    // R4 load six bytes
    tag = "R4";
    for (int i = 0; i < 6; i++) begin
      pat[i] = (8'h10 + i * 7) % 256;
      hostWrite(4'hF, 8'(pat[i]));
    end

    // R9 engine requests ignored while host owns
    tag = "R9";
    engPull(3);
    check("R9", "engValid while host owns", int'(engValid), 0);

    // R3 pointer clear on ownership rise, R5 readback, R7 ignored write
    tag = "R3";
    hostWrite(4'h4, 8'h00);
    hostWrite(4'h4, 8'h18);
    hostRead(4'hF, rd); check("R3", "first byte after re-own", rd, pat[0]);
    tag = "R5";
    for (int i = 1; i < 3; i++) begin
      hostRead(4'hF, rd); check("R5", "readback", rd, pat[i]);
    end
    tag = "R7";
    hostWrite(4'hF, 8'hEE);
    for (int i = 3; i < 6; i++) begin
      hostRead(4'hF, rd); check("R7", "readback after ignored write", rd, pat[i]);
    end

    // R7 engine mode: window reads zero, writes ignored
    hostWrite(4'h4, 8'h00);
    hostRead(4'hF, rd); check("R7", "window read in engine mode", rd, 0);
    hostWrite(4'hF, 8'h77);

    // R8 engine sequence, period 6
    tag = "R8";
    engPull(18);
    for (int i = 0; i < 18; i++)
      check("R8", "engine byte", engQ[i], pat[i % 6]);

    // R10 pattern end above 255 (299)
    tag = "R10";
    hostWrite(4'h4, 8'h08);
    for (int i = 0; i < 300; i++) begin
      pat[i] = (i * 3 + 8'h5A) % 256;
      hostWrite(4'hF, 8'(pat[i]));
    end
    hostWrite(4'h3, 8'(299 % 256));
    hostWrite(4'h4, 8'h01);
    hostRead(4'h4, rd); check("R10", "ctrl with end bit 8", rd, 8'h01);
    engPull(620);
    for (int i = 0; i < 620; i++)
      check("R10", "engine byte long period", engQ[i], pat[i % 300]);

    // R6 pointer wrap after 512 writes
    tag = "R6";
    hostWrite(4'h4, 8'h08);
    for (int i = 0; i < 512; i++) hostWrite(4'hF, 8'(i ^ 8'hA5));
    hostWrite(4'hF, 8'h3C);
    hostWrite(4'h4, 8'h00);
    hostWrite(4'h4, 8'h18);
    hostRead(4'hF, rd); check("R6", "address 0 overwritten", rd, 8'h3C);
    hostRead(4'hF, rd); check("R6", "address 1 intact", rd, 1 ^ 8'hA5);

    // R11 hold between strobes
    tag = "R11";
    repeat (2) @(negedge clk);
    check("R11", "read data holds", int'(hostRdData), 1 ^ 8'hA5);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule